// File: doc/BRIEF.md
# Pulse-Height Spectrum Accumulator

The block builds pulse-height histograms in an external memory that is only one byte wide. Each detected event comes with a 4-bit amplitude channel, taken from a 16-level discriminator ladder, and a spectrum selector. Together they name one 16-bit bin. A sequencer fetches the bin as two bytes, adds one and stores both bytes back. When the sequencer is idle, a host port with 16-bit data can read any bin or zero it.

A bank of independent event scalers runs beside the histogram. Each scaler has a sticky wrap flag. A single snapshot strobe copies every count and flag into a holding buffer and restarts the live counters in the same cycle.

With the default parameters the memory holds 256 spectra of 16 bins each, which is 4096 words or 8192 bytes.

Top module: `spec_hist_acc`

## Requirements
- R1: After reset, `busy`, `ram_we`, `host_ack` and `drop_count` are 0, and every scaler buffer and buffered flag is 0.
- R2: A bin's word address is {spectrum, channel}. The byte address appends one more bit below it: 0 selects the low byte and 1 selects the high byte.
- R3: An accepted event presents the low-byte read address in the first busy cycle and the high-byte read address in the second. It writes the low byte in the fourth busy cycle and the high byte in the fifth, and `busy` is low again in the sixth.
- R4: Each accepted event raises its bin by exactly one, with the carry passing from the low byte into the high byte.
- R5: A bin holding 0xFFFF stays at 0xFFFF when further events hit it.
- R6: An `evt_start` seen while `busy` is high leaves memory untouched and adds one to `drop_count`, which saturates at its maximum.
- R7: A host read returns the 16-bit bin on `host_rdata`, and `host_ack` is high for one cycle at that time.
- R8: A host clear writes 0 to both bytes of the bin and then pulses `host_ack`.
- R9: If `evt_start` and `host_req` both arrive in an idle cycle, the event runs first. The host operation starts in the first idle cycle after the event and sees the updated bin, so a read acknowledges ten cycles after the request.
- R10: `host_ack` is only ever high while `busy` is low, and no host operation starts while the sequencer is busy.
- R11: A snapshot copies each live count into its buffer and restarts the counter in the same cycle. An increment that arrives in the snapshot cycle is counted in the new interval. Buffers hold their values between snapshots.
- R12: A scaler sets its live wrap flag when it rolls over from all-ones to zero. A snapshot copies the flag into the buffered flag and clears the live flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_start | input | 1 | Event strobe, one cycle |
| evt_spectrum | input | SPEC_BITS | Spectrum selector |
| evt_channel | input | 4 | Discriminator channel |
| busy | output | 1 | Sequencer not idle |
| drop_count | output | DROP_W | Saturating count of rejected events |
| ram_addr | output | SPEC_BITS+5 | Byte address to the memory |
| ram_wdata | output | 8 | Write byte |
| ram_we | output | 1 | Write enable |
| ram_rdata | input | 8 | Read byte, valid one cycle after the address |
| host_req | input | 1 | Host request, held until acknowledged |
| host_clear | input | 1 | 1 = zero the bin, 0 = read it |
| host_addr | input | SPEC_BITS+4 | Host word address |
| host_rdata | output | 16 | Bin value returned by a read |
| host_ack | output | 1 | One-cycle completion pulse |
| scaler_inc | input | N_SCALERS | Per-scaler increment |
| scaler_snap | input | 1 | Snapshot strobe |
| scaler_buf | output | N_SCALERS*SCALER_W | Buffered counts, scaler i at bits [i*W +: W] |
| scaler_ovf | output | N_SCALERS | Buffered wrap flags |

## Verification
Two pairs of functions can fall in the same cycle. The first is an event start and a host read of the same bin, raised in one idle cycle. The bench checks that the event finishes first, that the acknowledge comes exactly ten cycles after the request, and that the value returned includes the increment. The second is a snapshot strobe given together with scaler increments. The bench judges it on the next snapshot, which must show exactly the increments from the shared cycle.

// File: rtl/spec_hist_pkg.sv
package spec_hist_pkg;
    localparam int BYTE_W  = 8;
    localparam int BIN_W   = 16;
    localparam int CH_BITS = 4;

    typedef enum logic [2:0] {
        S_IDLE, S_RD_LO, S_RD_HI, S_CAP, S_WR_LO, S_WR_HI
    } seq_state_t;

    typedef enum logic [1:0] {
        OP_EVT, OP_HRD, OP_HCLR
    } seq_op_t;

    // saturating increment of one histogram bin
    function automatic logic [BIN_W-1:0] bin_bump(input logic [BIN_W-1:0] v);
        return (v == {BIN_W{1'b1}}) ? v : v + 1'b1;
    endfunction
endpackage

// File: rtl/spec_drop_ctr.sv
module spec_drop_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bump,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (bump && count != {W{1'b1}})
            count <= count + 1'b1;
    end

    assert_drop_step_R6: assert property (@(posedge clk) disable iff (rst)
        (bump && count != {W{1'b1}}) |=> count == $past(count) + 1'b1);
    assert_drop_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !bump |=> $stable(count));
endmodule

// File: rtl/spec_scaler_cell.sv
module spec_scaler_cell #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         snap,
    output logic [W-1:0] snap_val,
    output logic         snap_ovf
);
    logic [W-1:0] cnt;
    logic         ovf;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            ovf      <= 1'b0;
            snap_val <= '0;
            snap_ovf <= 1'b0;
        end else if (snap) begin
            snap_val <= cnt;
            snap_ovf <= ovf;
            cnt      <= inc ? W'(1) : '0;
            ovf      <= 1'b0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
            if (cnt == {W{1'b1}})
                ovf <= 1'b1;
        end
    end

    assert_snap_restart_R11: assert property (@(posedge clk) disable iff (rst)
        snap |=> cnt <= W'(1));
    assert_buf_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !snap |=> ($stable(snap_val) && $stable(snap_ovf)));
    assert_ovf_sticky_R12: assert property (@(posedge clk) disable iff (rst)
        (ovf && !snap) |=> ovf);
endmodule

// File: rtl/spec_hist_seq.sv
module spec_hist_seq
    import spec_hist_pkg::*;
#(
    parameter int SPEC_BITS = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  evt_start,
    input  logic [SPEC_BITS-1:0]  evt_spectrum,
    input  logic [CH_BITS-1:0]    evt_channel,
    input  logic                  host_req,
    input  logic                  host_clear,
    input  logic [SPEC_BITS+CH_BITS-1:0] host_addr,
    input  logic [BYTE_W-1:0]     ram_rdata,
    output logic [SPEC_BITS+CH_BITS:0]   ram_addr,
    output logic [BYTE_W-1:0]     ram_wdata,
    output logic                  ram_we,
    output logic [BIN_W-1:0]      host_rdata,
    output logic                  host_ack,
    output logic                  busy
);
    localparam int WA_W = SPEC_BITS + CH_BITS;
    localparam int BA_W = WA_W + 1;

    seq_state_t       state;
    seq_op_t          op;
    logic [WA_W-1:0]  word_q;
    logic [BYTE_W-1:0] lo_q, hi_q;
    logic [BIN_W-1:0] next_bin;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            op         <= OP_EVT;
            word_q     <= '0;
            lo_q       <= '0;
            hi_q       <= '0;
            host_rdata <= '0;
            host_ack   <= 1'b0;
        end else begin
            host_ack <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (evt_start) begin
                        op     <= OP_EVT;
                        word_q <= {evt_spectrum, evt_channel};
                        state  <= S_RD_LO;
                    end else if (host_req && !host_ack) begin
                        word_q <= host_addr;
                        if (host_clear) begin
                            op    <= OP_HCLR;
                            state <= S_WR_LO;
                        end else begin
                            op    <= OP_HRD;
                            state <= S_RD_LO;
                        end
                    end
                end
                S_RD_LO: state <= S_RD_HI;
                S_RD_HI: begin
                    lo_q  <= ram_rdata;
                    state <= S_CAP;
                end
                S_CAP: begin
                    hi_q <= ram_rdata;
                    if (op == OP_HRD) begin
                        host_rdata <= {ram_rdata, lo_q};
                        host_ack   <= 1'b1;
                        state      <= S_IDLE;
                    end else begin
                        state <= S_WR_LO;
                    end
                end
                S_WR_LO: state <= S_WR_HI;
                S_WR_HI: begin
                    if (op == OP_HCLR)
                        host_ack <= 1'b1;
                    state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        next_bin  = (op == OP_HCLR) ? '0 : bin_bump({hi_q, lo_q});
        ram_we    = 1'b0;
        ram_wdata = '0;
        ram_addr  = {word_q, 1'b0};
        case (state)
            S_RD_HI: ram_addr = {word_q, 1'b1};
            S_WR_LO: begin
                ram_we    = 1'b1;
                ram_wdata = next_bin[BYTE_W-1:0];
            end
            S_WR_HI: begin
                ram_we    = 1'b1;
                ram_addr  = {word_q, 1'b1};
                ram_wdata = next_bin[BIN_W-1:BYTE_W];
            end
            default: ;
        endcase
    end

    assign busy = (state != S_IDLE);

    assert_write_pair_R3: assert property (@(posedge clk) disable iff (rst)
        (ram_we && !ram_addr[0]) |=> (ram_we && ram_addr[0] &&
            ram_addr[BA_W-1:1] == $past(ram_addr[BA_W-1:1])));
    assert_read_order_R3: assert property (@(posedge clk) disable iff (rst)
        (state == S_RD_LO) |=> (!ram_we && ram_addr[0]));
    assert_no_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (ram_we && ram_addr[0] && op == OP_EVT) |->
            !(ram_wdata == '0 && $past(ram_wdata) == '0));
    assert_ack_idle_R10: assert property (@(posedge clk) disable iff (rst)
        host_ack |-> !busy);
    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (ram_we && op == OP_HCLR) |-> ram_wdata == '0);
endmodule

// File: rtl/spec_hist_acc.sv
module spec_hist_acc
    import spec_hist_pkg::*;
#(
    parameter int SPEC_BITS = 8,
    parameter int N_SCALERS = 8,
    parameter int SCALER_W  = 16,
    parameter int DROP_W    = 8
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            evt_start,
    input  logic [SPEC_BITS-1:0]            evt_spectrum,
    input  logic [3:0]                      evt_channel,
    output logic                            busy,
    output logic [DROP_W-1:0]               drop_count,
    output logic [SPEC_BITS+4:0]            ram_addr,
    output logic [7:0]                      ram_wdata,
    output logic                            ram_we,
    input  logic [7:0]                      ram_rdata,
    input  logic                            host_req,
    input  logic                            host_clear,
    input  logic [SPEC_BITS+3:0]            host_addr,
    output logic [15:0]                     host_rdata,
    output logic                            host_ack,
    input  logic [N_SCALERS-1:0]            scaler_inc,
    input  logic                            scaler_snap,
    output logic [N_SCALERS*SCALER_W-1:0]   scaler_buf,
    output logic [N_SCALERS-1:0]            scaler_ovf
);
    logic busy_w;

    spec_hist_seq #(.SPEC_BITS(SPEC_BITS)) u_seq (
        .clk(clk), .rst(rst),
        .evt_start(evt_start), .evt_spectrum(evt_spectrum), .evt_channel(evt_channel),
        .host_req(host_req), .host_clear(host_clear), .host_addr(host_addr),
        .ram_rdata(ram_rdata), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .ram_we(ram_we), .host_rdata(host_rdata), .host_ack(host_ack),
        .busy(busy_w)
    );

    assign busy = busy_w;

    spec_drop_ctr #(.W(DROP_W)) u_drop (
        .clk(clk), .rst(rst), .bump(evt_start && busy_w), .count(drop_count)
    );

    for (genvar i = 0; i < N_SCALERS; i++) begin : g_scaler
        spec_scaler_cell #(.W(SCALER_W)) u_cell (
            .clk(clk), .rst(rst),
            .inc(scaler_inc[i]), .snap(scaler_snap),
            .snap_val(scaler_buf[i*SCALER_W +: SCALER_W]),
            .snap_ovf(scaler_ovf[i])
        );
    end
endmodule

// File: tb/spec_hist_acc_test.sv
module spec_hist_acc_test;
    localparam int SB = 3;
    localparam int NW = 1 << (SB + 4);

    logic clk = 0;
    always #4 clk = ~clk;

    logic rst, evt_start, host_req, host_clear, scaler_snap;
    logic [SB-1:0] evt_spectrum;
    logic [3:0] evt_channel;
    logic [SB+3:0] host_addr;
    logic [7:0] scaler_inc;
    logic busy, ram_we, host_ack;
    logic [7:0] drop_count, ram_wdata, ram_rdata;
    logic [SB+4:0] ram_addr;
    logic [15:0] host_rdata;
    logic [127:0] scaler_buf;
    logic [7:0] scaler_ovf;

    spec_hist_acc #(.SPEC_BITS(SB), .N_SCALERS(8), .SCALER_W(16), .DROP_W(8)) uut (
        .clk(clk), .rst(rst), .evt_start(evt_start), .evt_spectrum(evt_spectrum),
        .evt_channel(evt_channel), .busy(busy), .drop_count(drop_count),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we), .ram_rdata(ram_rdata),
        .host_req(host_req), .host_clear(host_clear), .host_addr(host_addr),
        .host_rdata(host_rdata), .host_ack(host_ack), .scaler_inc(scaler_inc),
        .scaler_snap(scaler_snap), .scaler_buf(scaler_buf), .scaler_ovf(scaler_ovf)
    );

    logic [7:0] mem [0:2*NW-1];
    always @(posedge clk) begin
        if (ram_we) mem[ram_addr] <= ram_wdata;
        ram_rdata <= mem[ram_addr];
    end

    int checks = 0, fails = 0;
    int model [0:NW-1];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_idle();
        int g = 0;
        while (busy && g < 100) begin @(negedge clk); g++; end
    endtask

    task automatic send_event(input int s, input int c);
        evt_start = 1; evt_spectrum = SB'(s); evt_channel = 4'(c);
        @(negedge clk);
        evt_start = 0;
        wait_idle();
    endtask

    task automatic host_op(input int w, input bit clr, output int val);
        int g = 0;
        host_req = 1; host_clear = clr; host_addr = (SB+4)'(w);
        @(negedge clk);
        while (!host_ack && g < 100) begin @(negedge clk); g++; end
        val = host_rdata;
        host_req = 0; host_clear = 0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int v, exp_v, w;
        rst = 1; evt_start = 0; host_req = 0; host_clear = 0; scaler_snap = 0;
        evt_spectrum = 0; evt_channel = 0; host_addr = 0; scaler_inc = 0;
        for (int b = 0; b < 2*NW; b++) mem[b] = 8'((b * 37 + 11) & 8'hFF);
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk(!busy && !ram_we && !host_ack, "R1 ctrl", {busy, ram_we, host_ack}, 0);
        chk(drop_count == 0, "R1 drop", drop_count, 0);
        chk(scaler_buf == '0 && scaler_ovf == '0, "R1 scalers", scaler_ovf, 0);

        // R7 host read of every preset word
        for (int i = 0; i < NW; i++) begin
            exp_v = ((((2*i+1) * 37 + 11) & 255) << 8) | (((2*i) * 37 + 11) & 255);
            host_op(i, 0, v);
            chk(v == exp_v, "R7 read", v, exp_v);
        end
        // R8 clear all, read back zero
        for (int i = 0; i < NW; i++) host_op(i, 1, v);
        for (int i = 0; i < NW; i++) begin
            host_op(i, 0, v);
            chk(v == 0, "R8 clear", v, 0);
            model[i] = 0;
        end

        // R2 and R3 address and ordering for spectrum 5 channel 9
        evt_start = 1; evt_spectrum = 3'd5; evt_channel = 4'd9;
        @(negedge clk); evt_start = 0;
        w = (5 << 4) | 9;
        chk(busy && !ram_we && ram_addr == (SB+5)'(2*w), "R2 rd lo addr", ram_addr, 2*w);
        @(negedge clk);
        chk(!ram_we && ram_addr == (SB+5)'(2*w+1), "R3 rd hi addr", ram_addr, 2*w+1);
        @(negedge clk);
        chk(!ram_we && busy, "R3 capture", ram_we, 0);
        @(negedge clk);
        chk(ram_we && ram_addr == (SB+5)'(2*w) && ram_wdata == 8'h01, "R3 wr lo", ram_wdata, 1);
        @(negedge clk);
        chk(ram_we && ram_addr == (SB+5)'(2*w+1) && ram_wdata == 8'h00, "R3 wr hi", ram_addr, 2*w+1);
        @(negedge clk);
        chk(!busy, "R3 idle", busy, 0);
        model[w] = 1;

        // R4 sweep: every bin gets (s+c)%4+1 events
        for (int s = 0; s < (1 << SB); s++)
            for (int c = 0; c < 16; c++)
                for (int k = 0; k < (s + c) % 4 + 1; k++) begin
                    send_event(s, c);
                    model[(s << 4) | c]++;
                end
        for (int i = 0; i < NW; i++) begin
            host_op(i, 0, v);
            chk(v == model[i], "R4 bin count", v, model[i]);
        end

        // R4 carry and R5 saturation
        mem[18] = 8'hFF; mem[19] = 8'h00;
        send_event(0, 9);
        host_op(9, 0, v);
        chk(v == 16'h0100, "R4 carry", v, 16'h0100);
        mem[6] = 8'hFE; mem[7] = 8'hFF;
        send_event(0, 3); send_event(0, 3); send_event(0, 3);
        host_op(3, 0, v);
        chk(v == 16'hFFFF, "R5 saturate", v, 16'hFFFF);
        model[3] = 16'hFFFF; model[9] = 16'h0100;

        // R6 drops while busy
        chk(drop_count == 0, "R6 no drops yet", drop_count, 0);
        evt_start = 1; evt_spectrum = 3'd2; evt_channel = 4'd4;
        @(negedge clk); @(negedge clk); @(negedge clk);
        evt_start = 0;
        wait_idle();
        chk(drop_count == 2, "R6 drop count", drop_count, 2);
        host_op(8'h24, 0, v);
        chk(v == model[8'h24] + 1, "R6 single update", v, model[8'h24] + 1);
        model[8'h24]++;

        // R9 and R10 collision of event and host read
        begin
            int cyc = 0; bit early = 0;
            w = (6 << 4) | 1;
            evt_start = 1; evt_spectrum = 3'd6; evt_channel = 4'd1;
            host_req = 1; host_clear = 0; host_addr = (SB+4)'(w);
            @(negedge clk); evt_start = 0; cyc = 1;
            while (!host_ack && cyc < 40) begin
                if (busy && cyc <= 5 && host_ack) early = 1;
                @(negedge clk); cyc++;
            end
            v = host_rdata; host_req = 0;
            chk(!early && !busy, "R10 ack only idle", busy, 0);
            chk(cyc == 10, "R9 ack latency", cyc, 10);
            chk(v == model[w] + 1, "R9 event first", v, model[w] + 1);
        end

        // R11 scaler counts and snapshot
        for (int t = 0; t < 30; t++) begin
            for (int i = 0; i < 8; i++) scaler_inc[i] = (t < i*3 + 1);
            @(negedge clk);
        end
        scaler_inc = 0; scaler_snap = 1; @(negedge clk); scaler_snap = 0;
        for (int i = 0; i < 8; i++)
            chk(scaler_buf[i*16 +: 16] == 16'(i*3+1), "R11 snapshot", scaler_buf[i*16 +: 16], i*3+1);
        chk(scaler_ovf == 0, "R12 no wrap", scaler_ovf, 0);
        // snapshot together with increments
        scaler_inc = 8'hA5; scaler_snap = 1; @(negedge clk);
        scaler_inc = 0; scaler_snap = 0;
        chk(scaler_buf == '0, "R11 restarted", scaler_buf[15:0], 0);
        repeat (3) @(negedge clk);
        chk(scaler_buf == '0, "R11 buffer holds", scaler_buf[15:0], 0);
        scaler_snap = 1; @(negedge clk); scaler_snap = 0;
        for (int i = 0; i < 8; i++)
            chk(scaler_buf[i*16 +: 16] == 16'((8'hA5 >> i) & 1), "R11 same-cycle inc",
                scaler_buf[i*16 +: 16], (8'hA5 >> i) & 1);

        // R12 wrap flag
        scaler_inc = 8'h80;
        repeat (65537) @(negedge clk);
        scaler_inc = 0; scaler_snap = 1; @(negedge clk); scaler_snap = 0;
        chk(scaler_buf[112 +: 16] == 16'd1, "R12 wrapped count", scaler_buf[112 +: 16], 1);
        chk(scaler_ovf == 8'h80, "R12 flag", scaler_ovf, 8'h80);
        scaler_snap = 1; @(negedge clk); scaler_snap = 0;
        chk(scaler_ovf == 0, "R12 flag cleared", scaler_ovf, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule